// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Controller

This block is the presentation stage that sits between an interrupt source layer and one processor. It holds at most one pending interrupt, the processor's current priority threshold, the priority of that pending interrupt, and a separate priority register for a software inter-processor interrupt (IPI). Smaller priority numbers are more urgent. When a more urgent request arrives, the block displaces the current pending source by handing it back to the source layer as a reject. It then latches the newcomer and raises the processor's interrupt line.

The source layer offers requests as a source number and a priority. It receives three kinds of single-cycle notices: reject, resend and end-of-interrupt. The processor talks to the block through a valid/ready command port with four operations. It can write its priority threshold, write the IPI priority, accept the pending interrupt (a read that returns a 32-bit word), or signal end-of-interrupt. The returned word carries the priority threshold in bits 31:24 and the pending source number in bits 23:0. A source field of zero means nothing is pending. A source request and a processor command are never handled in the same cycle; the source request goes first.

Top module: `irq_present_ctrl`

## Requirements
- R1: After reset the interrupt line is low, no notice is issued, and an accept returns 0x00000000 (threshold 0, nothing pending); the IPI priority starts at 0xFF.
- R2: A source request whose priority is numerically at or above the current threshold is handed back as a reject pulse carrying its own source number, one cycle later; pending state and line are unchanged.
- R3: A source request is also rejected when something is already pending whose priority is numerically at or below the request's priority (ties favour the incumbent).
- R4: A request that passes both tests displaces any pending source with a reject pulse, and then latches its number and priority. The interrupt line is high exactly while a source is pending.
- R5: An accept (cmd_op 2) returns {threshold, pending source} on rsp_data with rsp_valid one cycle later. It lowers the line, clears the source field and sets the threshold to the pending priority.
- R6: An end-of-interrupt (cmd_op 3) pulses eoi_valid with cmd_data[23:0] and copies cmd_data[31:24] into the threshold. If nothing is pending afterwards, it pulses rsnd_valid in the same cycle.
- R7: A threshold write (cmd_op 0, value in cmd_data[31:24]) that is numerically lower than the old threshold clears the pending source only when one is pending and the new value is at or below its priority. In that case the line drops and the cleared source is rejected. Otherwise the write changes only the threshold.
- R8: A threshold write that is not lower than the old threshold triggers a resend when nothing is pending; a lowering write with nothing pending issues no notice.
- R9: An IPI priority write (cmd_op 1, value in cmd_data[7:0]) below the threshold runs the IPI check. The check rejects any less urgent pending source, loads source number 2 with the IPI priority, and raises the line.
- R10: The IPI check leaves everything unchanged when a pending source has priority numerically at or below the IPI priority. An IPI write at or above the threshold only stores the value.
- R11: Every resend first runs the IPI check when the IPI priority is below the (updated) threshold, then pulses rsnd_valid.
- R12: While req_valid is high, cmd_ready is low and the processor command is not executed.
- R13: A source request with source number 0 is ignored: no notice and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Source layer presents a request |
| req_src | input | 24 | Requesting source number |
| req_prio | input | 8 | Requested priority (lower is more urgent) |
| rej_valid | output | 1 | Reject notice pulse |
| rej_src | output | 24 | Source number being rejected |
| rsnd_valid | output | 1 | Resend notice pulse |
| eoi_valid | output | 1 | End-of-interrupt notice pulse |
| eoi_src | output | 24 | Source number being completed |
| cmd_valid | input | 1 | Processor command valid |
| cmd_ready | output | 1 | Command accepted this cycle |
| cmd_op | input | 2 | 0 threshold write, 1 IPI write, 2 accept, 3 end-of-interrupt |
| cmd_data | input | 32 | Command operand |
| rsp_valid | output | 1 | Accept result valid |
| rsp_data | output | 32 | Accept result {threshold, source} |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
The bench builds the block with its default parameters: 8-bit priorities, 24-bit source numbers and IPI source number 2. With these values, equal-priority ties against both the threshold and the pending priority can be reached in a few commands. So can the initial 0xFF IPI priority, which never passes the check, and the chain in which an end-of-interrupt causes a resend that reloads the IPI. A reference model built from the requirements predicts every notice and accept word into a scoreboard queue. A monitor pops that queue and compares as pulses appear, and the line level is checked after every operation.

// File: rtl/irqp_pkg.sv
// Shared widths, operation codes and record types for the interrupt
// presentation controller. Assumes priorities and source numbers pack
// into one 32-bit accept word.
package irqp_pkg;
    localparam int PRIO_W = 8;
    localparam int SRC_W  = 24;
    localparam int WORD_W = PRIO_W + SRC_W;

    typedef enum logic [1:0] {
        OP_THRESH = 2'd0,
        OP_IPI    = 2'd1,
        OP_ACCEPT = 2'd2,
        OP_EOI    = 2'd3
    } irqp_op_e;

    // Architectural state of one presentation point.
    typedef struct packed {
        logic [PRIO_W-1:0] thresh;
        logic [SRC_W-1:0]  src;
        logic [PRIO_W-1:0] pprio;
        logic [PRIO_W-1:0] ipi_prio;
        logic              line;
    } irqp_state_t;

    // Notices and response produced in one cycle.
    typedef struct packed {
        logic              rej_v;
        logic [SRC_W-1:0]  rej_src;
        logic              rsnd_v;
        logic              eoi_v;
        logic [SRC_W-1:0]  eoi_src;
        logic              rsp_v;
        logic [WORD_W-1:0] rsp_word;
    } irqp_notice_t;

    // True when running the IPI check would push out the pending source.
    function automatic logic ipi_displaces(irqp_state_t s);
        return (s.src != '0) && (s.pprio > s.ipi_prio);
    endfunction

    // State after the IPI check; caller has already compared against threshold.
    function automatic irqp_state_t ipi_step(irqp_state_t s, logic [SRC_W-1:0] ipi_src);
        irqp_state_t r;
        r = s;
        if (!((s.src != '0) && (s.pprio <= s.ipi_prio))) begin
            r.src   = ipi_src;
            r.pprio = s.ipi_prio;
            r.line  = 1'b1;
        end
        return r;
    endfunction
endpackage

// File: rtl/irqp_port.sv
// Command port arbitration: a source request always wins the cycle, so the
// processor command is held off with ready low. Assumes the processor keeps
// its command stable until ready is seen.
module irqp_port
    import irqp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic [SRC_W-1:0] req_src,
    input  logic cmd_valid,
    output logic cmd_ready,
    output logic req_fire,
    output logic cmd_fire
);
    // Grant the cycle: source first, zero source number is a no-op request.
    always_comb begin
        cmd_ready = !req_valid;
        req_fire  = req_valid && (req_src != '0);
        cmd_fire  = cmd_valid && !req_valid;
    end

    p_source_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (!cmd_ready && !cmd_fire));
endmodule

// File: rtl/irqp_core.sv
// Next-state logic of the presentation point: request arbitration against
// threshold and pending priority, the four processor operations, the IPI
// check and the resend path. Purely combinational; at most one reject per
// cycle follows because a resend only happens with nothing pending.
module irqp_core
    import irqp_pkg::*;
#(
    parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
    input  irqp_state_t        cur,
    input  logic               req_fire,
    input  logic [SRC_W-1:0]   req_src,
    input  logic [PRIO_W-1:0]  req_prio,
    input  logic               cmd_fire,
    input  irqp_op_e           cmd_op,
    input  logic [WORD_W-1:0]  cmd_data,
    output irqp_state_t        nxt,
    output irqp_notice_t       ntc
);
    logic              resend;
    logic [PRIO_W-1:0] new_thresh;

    assign new_thresh = cmd_data[WORD_W-1:SRC_W];

    // Compute the next state and the notices for the operation granted this cycle.
    always_comb begin
        nxt    = cur;
        ntc    = '0;
        resend = 1'b0;
        if (req_fire) begin
            if ((req_prio >= cur.thresh) ||
                ((cur.src != '0) && (cur.pprio <= req_prio))) begin
                ntc.rej_v   = 1'b1;
                ntc.rej_src = req_src;
            end else begin
                if (cur.src != '0) begin
                    ntc.rej_v   = 1'b1;
                    ntc.rej_src = cur.src;
                end
                nxt.src   = req_src;
                nxt.pprio = req_prio;
                nxt.line  = 1'b1;
            end
        end else if (cmd_fire) begin
            unique case (cmd_op)
                OP_THRESH: begin
                    nxt.thresh = new_thresh;
                    if (new_thresh < cur.thresh) begin
                        if ((cur.src != '0) && (new_thresh <= cur.pprio)) begin
                            ntc.rej_v   = 1'b1;
                            ntc.rej_src = cur.src;
                            nxt.src     = '0;
                            nxt.line    = 1'b0;
                        end
                    end else if (cur.src == '0) begin
                        resend = 1'b1;
                    end
                end
                OP_IPI: begin
                    nxt.ipi_prio = cmd_data[PRIO_W-1:0];
                    if (nxt.ipi_prio < cur.thresh) begin
                        if (ipi_displaces(nxt)) begin
                            ntc.rej_v   = 1'b1;
                            ntc.rej_src = cur.src;
                        end
                        nxt = ipi_step(nxt, IPI_SRC);
                    end
                end
                OP_ACCEPT: begin
                    ntc.rsp_v    = 1'b1;
                    ntc.rsp_word = {cur.thresh, cur.src};
                    nxt.src      = '0;
                    nxt.thresh   = cur.pprio;
                    nxt.line     = 1'b0;
                end
                OP_EOI: begin
                    ntc.eoi_v   = 1'b1;
                    ntc.eoi_src = cmd_data[SRC_W-1:0];
                    nxt.thresh  = new_thresh;
                    if (cur.src == '0) resend = 1'b1;
                end
                default: ;
            endcase
        end
        if (resend) begin
            if (nxt.ipi_prio < nxt.thresh) nxt = ipi_step(nxt, IPI_SRC);
            ntc.rsnd_v = 1'b1;
        end
    end
endmodule

// File: rtl/irqp_notice.sv
// Output register stage for the source-layer notices and the accept
// response, so every notice leaves as a clean one-cycle pulse.
module irqp_notice
    import irqp_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  irqp_notice_t ntc_d,
    output irqp_notice_t ntc_q
);
    // Register notices; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ntc_q <= '0;
        else        ntc_q <= ntc_d;
    end

    p_reject_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ntc_q.rej_v |-> (ntc_q.rej_src != '0));
    p_rsp_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ntc_q.rsp_v |-> (!ntc_q.eoi_v && !ntc_q.rsnd_v));
endmodule

// File: rtl/irq_present_ctrl.sv
// Per-processor interrupt presentation controller. Holds one pending source,
// the processor threshold and the IPI priority, arbitrates source requests
// against them and drives the processor's interrupt line. Assumes the source
// layer answers reject/resend notices itself; nothing here queues them.
module irq_present_ctrl
    import irqp_pkg::*;
#(
    parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [PRIO_W-1:0] req_prio,
    output logic              rej_valid,
    output logic [SRC_W-1:0]  rej_src,
    output logic              rsnd_valid,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              irq_o
);
    localparam logic [PRIO_W-1:0] IPI_IDLE = '1;

    irqp_state_t  st_q, st_d;
    irqp_notice_t ntc_d, ntc_q;
    logic         req_fire, cmd_fire;
    irqp_op_e     op;

    assign op = irqp_op_e'(cmd_op);

    irqp_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_src   (req_src),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .req_fire  (req_fire),
        .cmd_fire  (cmd_fire)
    );

    irqp_core #(.IPI_SRC(IPI_SRC)) u_core (
        .cur      (st_q),
        .req_fire (req_fire),
        .req_src  (req_src),
        .req_prio (req_prio),
        .cmd_fire (cmd_fire),
        .cmd_op   (op),
        .cmd_data (cmd_data),
        .nxt      (st_d),
        .ntc      (ntc_d)
    );

    irqp_notice u_notice (
        .clk   (clk),
        .rst_n (rst_n),
        .ntc_d (ntc_d),
        .ntc_q (ntc_q)
    );

    // Hold the architectural state; reset to idle with IPI priority least urgent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.ipi_prio <= IPI_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Drive the ports from the registered state and notices.
    always_comb begin
        irq_o      = st_q.line;
        rej_valid  = ntc_q.rej_v;
        rej_src    = ntc_q.rej_src;
        rsnd_valid = ntc_q.rsnd_v;
        eoi_valid  = ntc_q.eoi_v;
        eoi_src    = ntc_q.eoi_src;
        rsp_valid  = ntc_q.rsp_v;
        rsp_data   = ntc_q.rsp_word;
    end

    p_line_tracks_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (st_q.src != '0));
    p_accept_lowers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && op == OP_ACCEPT) |=> (!irq_o && rsp_valid));
    p_eoi_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && op == OP_EOI) |=> (eoi_valid && eoi_src == $past(cmd_data[SRC_W-1:0])));
    p_ipi_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && op == OP_IPI && st_q.src == '0 && cmd_data[PRIO_W-1:0] < st_q.thresh)
        |=> (irq_o && st_q.src == IPI_SRC));
    p_zero_src_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src == '0) |=> (!rej_valid && $stable(irq_o)));
endmodule

// File: tb/irq_present_ctrl_test.sv
module irq_present_ctrl_test;
    import irqp_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [SRC_W-1:0]  req_src = '0;
    logic [PRIO_W-1:0] req_prio = '0;
    logic              rej_valid, rsnd_valid, eoi_valid, cmd_ready, rsp_valid, irq_o;
    logic [SRC_W-1:0]  rej_src, eoi_src;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = '0;
    logic [WORD_W-1:0] cmd_data = '0;
    logic [WORD_W-1:0] rsp_data;

    always #2.5 clk = ~clk;

    irq_present_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
        .rej_valid(rej_valid), .rej_src(rej_src), .rsnd_valid(rsnd_valid),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .irq_o(irq_o)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Scoreboard item kinds, in the order the monitor scans them.
    localparam int K_RSP = 0, K_EOI = 1, K_REJ = 2, K_RSND = 3;
    typedef struct { int kind; logic [31:0] val; string tag; } exp_t;
    exp_t sb[$];

    // Reference model state, derived from the requirements.
    logic [7:0]  m_thr = 8'h00, m_pp = 8'h00, m_ipi = 8'hFF;
    logic [23:0] m_src = '0;
    bit          mon_on = 0;
    string       cur_tag = "R1";

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic void push(int k, logic [31:0] v, string tag);
        exp_t e;
        e.kind = k; e.val = v; e.tag = tag;
        sb.push_back(e);
    endfunction

    // IPI check of the model (R9, R10).
    function automatic void m_ipi_check(string tag);
        if (m_src != 0 && m_pp <= m_ipi) return;
        if (m_src != 0) push(K_REJ, {8'h0, m_src}, tag);
        m_src = 24'd2;
        m_pp  = m_ipi;
    endfunction

    // Resend of the model (R11).
    function automatic void m_resend(string tag);
        if (m_ipi < m_thr) m_ipi_check(tag);
        push(K_RSND, 0, tag);
    endfunction

    function automatic void m_present(logic [23:0] s, logic [7:0] p, string tag);
        if (s == 0) return;                               // R13
        if (p >= m_thr || (m_src != 0 && m_pp <= p)) begin // R2, R3
            push(K_REJ, {8'h0, s}, tag);
        end else begin                                     // R4
            if (m_src != 0) push(K_REJ, {8'h0, m_src}, tag);
            m_src = s; m_pp = p;
        end
    endfunction

    function automatic void m_cmd(logic [1:0] op, logic [31:0] d, string tag);
        logic [7:0] old;
        case (op)
            2'd0: begin                                    // R7, R8
                old = m_thr; m_thr = d[31:24];
                if (d[31:24] < old) begin
                    if (m_src != 0 && d[31:24] <= m_pp) begin
                        push(K_REJ, {8'h0, m_src}, tag);
                        m_src = 0;
                    end
                end else if (m_src == 0) m_resend(tag);
            end
            2'd1: begin                                    // R9, R10
                m_ipi = d[7:0];
                if (m_ipi < m_thr) m_ipi_check(tag);
            end
            2'd2: begin                                    // R5
                push(K_RSP, {m_thr, m_src}, tag);
                m_src = 0; m_thr = m_pp;
            end
            default: begin                                 // R6
                push(K_EOI, {8'h0, d[23:0]}, tag);
                m_thr = d[31:24];
                if (m_src == 0) m_resend(tag);
            end
        endcase
    endfunction

    // Monitor: compare each observed pulse against the front of the queue.
    task automatic observe(int k, logic [31:0] v);
        exp_t e;
        if (sb.size() == 0) begin
            chk(0, {cur_tag, " unexpected notice"}, v, {30'h0, k[1:0]});
        end else begin
            e = sb.pop_front();
            chk(e.kind == k && e.val == v, e.tag, v, e.val);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (rsp_valid)  observe(K_RSP, rsp_data);
            if (eoi_valid)  observe(K_EOI, {8'h0, eoi_src});
            if (rej_valid)  observe(K_REJ, {8'h0, rej_src});
            if (rsnd_valid) observe(K_RSND, 0);
        end
    end

    // Driver: one operation, then check line level and that all expectations were met.
    task automatic drive(bit rv, logic [23:0] s, logic [7:0] p,
                         bit cv, logic [1:0] op, logic [31:0] d, string tag);
        @(negedge clk);
        cur_tag = tag;
        req_valid = rv; req_src = s; req_prio = p;
        cmd_valid = cv; cmd_op = op; cmd_data = d;
        if (rv) m_present(s, p, tag);
        else if (cv) m_cmd(op, d, tag);
        #1;
        if (rv && cv) chk(cmd_ready == 1'b0, {tag, " cmd_ready"}, cmd_ready, 0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; cmd_valid = 0;
        #1;
        chk(irq_o == (m_src != 0), {tag, " irq"}, irq_o, (m_src != 0));
        chk(sb.size() == 0, {tag, " missing notice"}, sb.size(), 0);
        sb.delete();
    endtask

    task automatic present(logic [23:0] s, logic [7:0] p, string tag);
        drive(1, s, p, 0, 2'd0, 0, tag);
    endtask
    task automatic cmd(logic [1:0] op, logic [31:0] d, string tag);
        drive(0, 0, 0, 1, op, d, tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        chk(irq_o == 0 && !rej_valid && !rsnd_valid && !eoi_valid && !rsp_valid,
            "R1 reset outputs", {irq_o, rej_valid, rsnd_valid, eoi_valid, rsp_valid}, 0);
        mon_on = 1;
        cmd(2'd2, 0, "R1 accept after reset");           // returns 0
        present(24'h5, 8'h3, "R2 prio above threshold");
        cmd(2'd0, 32'h1000_0000, "R8 raise threshold resend");
        present(24'h5, 8'h4, "R4 latch first");
        present(24'h7, 8'h6, "R3 less urgent");
        present(24'h8, 8'h4, "R3 equal priority tie");
        present(24'h9, 8'h2, "R4 displace pending");
        present(24'h3, 8'h10, "R2 equal to threshold");
        cmd(2'd2, 0, "R5 accept");                        // 0x10000009
        cmd(2'd3, 32'h1000_0009, "R6 eoi with resend");
        present(24'h21, 8'h8, "R4 latch 0x21");
        cmd(2'd0, 32'h0C00_0000, "R7 lower but above pending");
        cmd(2'd0, 32'h0800_0000, "R7 lower clears pending");
        cmd(2'd0, 32'h0500_0000, "R8 lower with none pending");
        cmd(2'd0, 32'h2000_0000, "R8 raise resend");
        cmd(2'd1, 32'h0000_0030, "R10 ipi above threshold");
        cmd(2'd1, 32'h0000_000A, "R9 ipi loads");
        present(24'h44, 8'h0C, "R3 behind ipi");
        cmd(2'd1, 32'h0000_000C, "R10 ipi check no-op");
        cmd(2'd2, 0, "R5 accept ipi");                    // 0x20000002
        present(24'h50, 8'h3, "R4 latch 0x50");
        cmd(2'd1, 32'h0000_0001, "R9 ipi displaces");
        cmd(2'd2, 0, "R5 accept displaced ipi");
        cmd(2'd3, 32'h3000_0002, "R11 eoi resend reloads ipi");
        cmd(2'd2, 0, "R5 accept reloaded ipi");
        drive(1, 24'h60, 8'h0, 1, 2'd2, 0, "R12 request beats command");
        present(24'h0, 8'h0, "R13 zero source ignored");
        cmd(2'd2, 0, "R13 state intact after zero source");
        cmd(2'd3, 32'hFF00_0060, "R6 eoi no pending");
        cmd(2'd2, 0, "R5 threshold after eoi");
        finish_run();
    end
endmodule